// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register Block

This block holds the programming state of an I/O interrupt router. A bus master does not address the registers directly. It first writes a register number into a one-byte select register. It then reads or writes the chosen 32-bit register through a data window. The registers reached through the window are:

- an identification register;
- a version register, which software cannot change;
- an arbitration register, which mirrors the identification value;
- one 64-bit routing entry per input pin, reached as two 32-bit halves.

Every entry keeps two status bits that only the delivery engine may change. These are the remote-IRR bit, which the engine sets and clears through strobes, and the in-flight delivery bit, which the engine drives live. A bus write never disturbs either bit.

After every accepted table write, the block tells the delivery engine which entry changed. The engine then resets that entry's storm counter and rescans. A third offset accepts an explicit end-of-interrupt write and passes the vector on as a one-cycle broadcast. The whole table is also exported flat so the engine can see every entry.

Requests use a valid/ready handshake. A read returns its data on a response channel, also valid/ready. While a read response is waiting and `rsp_ready` is low, `req_ready` stays low, so a new request is held back until the response is taken. Writes produce no response. The change pulse and the end-of-interrupt pulse are plain one-cycle strobes.

Top module: `irq_route_regs`

## Requirements
- R1: After reset the select register is 0 and the ID is 0. Every entry reads 0x00010000 in its lower half (bit 16, mask, set) and 0 in its upper half.
- R2: Only `req_addr` bits 7:0 are decoded. Offset 0x00 is the select register, and a write stores `req_wdata[7:0]` while a read returns that byte zero-extended. Offset 0x10 is the data window and offset 0x40 is the end-of-interrupt register. Any other offset reads 0.
- R3: With select 0, a 32-bit window write stores `req_wdata[27:24]` as the ID. Window reads with select 0 (ID) or select 2 (arbitration) both return the ID in bits 27:24 and zero elsewhere.
- R4: With select 1, a window read returns VERSION in bits 7:0 OR'd with (NPINS-1) in bits 23:16. Window writes with select 1 or select 2 change nothing.
- R5: A select value s of 0x10 or above addresses entry (s-0x10)>>1. Odd s reaches entry bits 63:32 and even s reaches bits 31:0. An entry index of NPINS or more, or s below 0x10, reads 0 and ignores writes.
- R6: Only bits 11:0, 13, 15, 16 and 63:56 of an entry are stored from a write. All other bits read 0, except bit 12 (delivery busy, the live `pin_busy` value) and bit 14 (remote IRR), which writes cannot alter.
- R7: A table write that leaves bit 15 (trigger mode: 1 = level, 0 = edge) at 0 clears the entry's remote-IRR bit.
- R8: Each accepted in-range 32-bit table write pulses `ent_chg_valid` for one cycle, with `ent_chg_idx` equal to the entry index, in the cycle after acceptance. No other request pulses it.
- R9: A window access with `req_full` low is ignored. Its read returns 0.
- R10: A 32-bit write to offset 0x40 pulses `eoi_valid` one cycle later with `eoi_vector` = `req_wdata[7:0]`, but only when VERSION is 0x20. Allowed VERSION values are 0x11 and 0x20, and 0x20 is the default.
- R11: A read response stays valid, with stable data, until `rsp_ready` is high. `req_ready` is low while a response is pending and `rsp_ready` is low.
- R12: `rirr_set[i]` sets and `rirr_clr[i]` clears entry i's remote IRR. Set wins over clear. A set in the same cycle as a level-mode write to that entry survives, and an edge-mode write in that cycle clears the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset (low 8 address bits) |
| req_full | input | 1 | 1 = 32-bit access |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_ready | input | 1 | Read data taken |
| rsp_rdata | output | 32 | Read data |
| pin_busy | input | NPINS | Live delivery-busy status per pin |
| rirr_set | input | NPINS | Remote-IRR set strobes from the delivery engine |
| rirr_clr | input | NPINS | Remote-IRR clear strobes from the delivery engine |
| table_flat | output | NPINS*64 | All stored entries, entry i at bits i*64+63:i*64 |
| ent_chg_valid | output | 1 | One-cycle pulse after a table write |
| ent_chg_idx | output | $clog2(NPINS) | Index of the changed entry |
| eoi_valid | output | 1 | One-cycle end-of-interrupt broadcast |
| eoi_vector | output | 8 | Broadcast vector |

## Verification
Two things can land on one entry in the same clock: a bus write to its lower half and a remote-IRR strobe from the delivery engine. The bench raises `rirr_set` in exactly the cycle that a table write is accepted. It does this once with a level-mode value and once with an edge-mode value. It then reads the entry back and expects bit 14 to be kept in the first case and cleared in the second. A simultaneous set and clear strobe is also provoked and must leave the bit set.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned ENT_W = 64;
  localparam int unsigned RIRR_BIT = 14;
  localparam int unsigned BUSY_BIT = 12;
  localparam int unsigned TRIG_BIT = 15;
  localparam logic [ENT_W-1:0] RW_MASK = 64'hFF00_0000_0001_AFFF;
  localparam logic [ENT_W-1:0] ENT_RESET = 64'h0000_0000_0001_0000;

  localparam logic [7:0] OFF_SEL = 8'h00;
  localparam logic [7:0] OFF_WIN = 8'h10;
  localparam logic [7:0] OFF_EOI = 8'h40;

  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;

  localparam int unsigned ID_W = 4;
  localparam int unsigned ID_LSB = 24;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_ID,
    RK_VER,
    RK_ARB,
    RK_TBL
  } reg_kind_e;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  localparam int unsigned IDX_W = $clog2(NPINS)
) (
  input  logic [7:0]       off,
  input  logic [7:0]       sel,
  output logic             is_sel,
  output logic             is_win,
  output logic             is_eoi,
  output reg_kind_e        kind,
  output logic             tbl_upper,
  output logic [IDX_W-1:0] tbl_idx
);
  logic [6:0] rel_idx;
  logic       in_tbl;

  assign is_sel = (off == OFF_SEL);
  assign is_win = (off == OFF_WIN);
  assign is_eoi = (off == OFF_EOI);

  assign rel_idx   = sel[7:1] - 7'h08;
  assign in_tbl    = (sel[7:1] >= 7'h08) && (rel_idx < 7'(NPINS));
  assign tbl_upper = sel[0];
  assign tbl_idx   = rel_idx[IDX_W-1:0];

  always_comb begin
    if (sel == SEL_ID)       kind = RK_ID;
    else if (sel == SEL_VER) kind = RK_VER;
    else if (sel == SEL_ARB) kind = RK_ARB;
    else if (in_tbl)         kind = RK_TBL;
    else                     kind = RK_NONE;
  end
endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
  import irq_route_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  localparam int unsigned IDX_W = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic                   wr_upper,
  input  logic [31:0]            wr_data,
  input  logic [NPINS-1:0]       rirr_set,
  input  logic [NPINS-1:0]       rirr_clr,
  input  logic [NPINS-1:0]       pin_busy,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic                   rd_upper,
  output logic [31:0]            rd_half,
  output logic [NPINS*ENT_W-1:0] table_flat
);
  logic [ENT_W-1:0] ent_view [NPINS];

  for (genvar i = 0; i < NPINS; i++) begin : g_ent
    logic [ENT_W-1:0] rw_q;
    logic             rirr_q;
    logic [ENT_W-1:0] merged;
    logic             hit;
    logic             rirr_d;

    assign hit    = wr_en && (wr_idx == IDX_W'(i));
    assign merged = wr_upper ? {wr_data, rw_q[31:0]} : {rw_q[63:32], wr_data};

    always_comb begin
      rirr_d = (rirr_q && !rirr_clr[i]) || rirr_set[i];
      if (hit && !merged[TRIG_BIT]) rirr_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rw_q   <= ENT_RESET;
        rirr_q <= 1'b0;
      end else begin
        if (hit) rw_q <= merged & RW_MASK;
        rirr_q <= rirr_d;
      end
    end

    assign table_flat[i*ENT_W +: ENT_W] = rw_q | (ENT_W'(rirr_q) << RIRR_BIT);
    assign ent_view[i] = table_flat[i*ENT_W +: ENT_W] | (ENT_W'(pin_busy[i]) << BUSY_BIT);
  end

  always_comb begin
    rd_half = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (rd_idx == IDX_W'(i)) rd_half = rd_upper ? ent_view[i][63:32] : ent_view[i][31:0];
    end
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  parameter logic [7:0]  VERSION = 8'h20,
  localparam int unsigned IDX_W = $clog2(NPINS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [7:0]             req_addr,
  input  logic                   req_full,
  input  logic [31:0]            req_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [31:0]            rsp_rdata,
  input  logic [NPINS-1:0]       pin_busy,
  input  logic [NPINS-1:0]       rirr_set,
  input  logic [NPINS-1:0]       rirr_clr,
  output logic [NPINS*ENT_W-1:0] table_flat,
  output logic                   ent_chg_valid,
  output logic [IDX_W-1:0]       ent_chg_idx,
  output logic                   eoi_valid,
  output logic [7:0]             eoi_vector
);
  localparam logic [31:0] VER_WORD = 32'(VERSION) | (32'(NPINS - 1) << 16);
  localparam bit EOI_ON = (VERSION == 8'h20);

  logic [7:0]      sel_q;
  logic [ID_W-1:0] id_q;
  logic            acc, is_sel, is_win, is_eoi, tbl_upper;
  logic            win_wr, tbl_we, eoi_fire;
  reg_kind_e       kind;
  logic [IDX_W-1:0] tbl_idx;
  logic [31:0]     tbl_half, rd_data, id_word;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc       = req_valid && req_ready;

  irq_route_decode #(.NPINS(NPINS)) u_dec (
    .off(req_addr), .sel(sel_q), .is_sel(is_sel), .is_win(is_win), .is_eoi(is_eoi),
    .kind(kind), .tbl_upper(tbl_upper), .tbl_idx(tbl_idx)
  );

  assign win_wr   = acc && req_write && req_full && is_win;
  assign tbl_we   = win_wr && (kind == RK_TBL);
  assign eoi_fire = acc && req_write && req_full && is_eoi && EOI_ON;

  irq_route_table #(.NPINS(NPINS)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_upper(tbl_upper),
    .wr_data(req_wdata), .rirr_set(rirr_set), .rirr_clr(rirr_clr), .pin_busy(pin_busy),
    .rd_idx(tbl_idx), .rd_upper(tbl_upper), .rd_half(tbl_half), .table_flat(table_flat)
  );

  assign id_word = 32'(id_q) << ID_LSB;

  always_comb begin
    rd_data = '0;
    if (is_sel) begin
      rd_data = {24'h0, sel_q};
    end else if (is_win && req_full) begin
      unique case (kind)
        RK_ID, RK_ARB: rd_data = id_word;
        RK_VER:        rd_data = VER_WORD;
        RK_TBL:        rd_data = tbl_half;
        default:       rd_data = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q         <= '0;
      id_q          <= '0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
      ent_chg_valid <= 1'b0;
      ent_chg_idx   <= '0;
      eoi_valid     <= 1'b0;
      eoi_vector    <= '0;
    end else begin
      if (acc && req_write && is_sel) sel_q <= req_wdata[7:0];
      if (win_wr && kind == RK_ID) id_q <= req_wdata[ID_LSB +: ID_W];
      if (acc && !req_write) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= rd_data;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      ent_chg_valid <= tbl_we;
      if (tbl_we) ent_chg_idx <= tbl_idx;
      eoi_valid <= eoi_fire;
      if (eoi_fire) eoi_vector <= req_wdata[7:0];
    end
  end
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk
  import irq_route_pkg::*;
#(
  parameter int unsigned NPINS = 24,
  parameter logic [7:0]  VERSION = 8'h20,
  localparam int unsigned IDX_W = $clog2(NPINS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic [7:0]             req_addr,
  input logic                   req_full,
  input logic [7:0]             wd_low,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [31:0]            rsp_rdata,
  input logic [NPINS*ENT_W-1:0] table_flat,
  input logic                   ent_chg_valid,
  input logic [IDX_W-1:0]       ent_chg_idx,
  input logic                   eoi_valid,
  input logic [7:0]             eoi_vector,
  input logic [7:0]             sel_q
);
  localparam logic [ENT_W-1:0] KEEP = RW_MASK | (64'h1 << RIRR_BIT);
  localparam bit EOI_ON = (VERSION == 8'h20);

  logic       acc, win_wr, eoi_wr, in_tbl;
  logic [6:0] rel;

  assign acc    = req_valid && req_ready;
  assign win_wr = acc && req_write && req_full && (req_addr == 8'h10);
  assign eoi_wr = acc && req_write && req_full && (req_addr == 8'h40);
  assign rel    = sel_q[7:1] - 7'd8;
  assign in_tbl = (sel_q[7:1] >= 7'd8) && (int'(rel) < NPINS) && (sel_q[0] || !sel_q[0]);

  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  assert_backpress_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  assert_chg_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr && in_tbl |=> ent_chg_valid && (ent_chg_idx == $past(rel[IDX_W-1:0])));
  assert_no_chg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_wr && in_tbl) |=> !ent_chg_valid);
  assert_eoi_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(eoi_wr && EOI_ON) |=> !eoi_valid);
  assert_eoi_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_wr && EOI_ON |=> eoi_valid && (eoi_vector == $past(wd_low)));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assert_edge_rirr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ent_chg_valid && (ent_chg_idx == IDX_W'(i)) && !table_flat[i*ENT_W + TRIG_BIT]
      |-> !table_flat[i*ENT_W + RIRR_BIT]);
    assert_ro_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (table_flat[i*ENT_W +: ENT_W] & ~KEEP) == '0);
  end
endmodule

bind irq_route_regs irq_route_regs_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .req_addr(req_addr), .req_full(req_full), .wd_low(req_wdata[7:0]),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .table_flat(table_flat), .ent_chg_valid(ent_chg_valid), .ent_chg_idx(ent_chg_idx),
  .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .sel_q(sel_q)
);

// File: tb/irq_route_regs_bench.sv
module irq_route_regs_bench;
  localparam int NPINS = 24;
  localparam int IDX_W = $clog2(NPINS);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_full = 1'b1;
  logic [7:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_ready = 1'b1;
  logic [NPINS-1:0] pin_busy = '0, rirr_set = '0, rirr_clr = '0;

  logic req_ready, rsp_valid, ent_chg_valid, eoi_valid;
  logic [31:0] rsp_rdata;
  logic [NPINS*64-1:0] table_flat;
  logic [IDX_W-1:0] ent_chg_idx;
  logic [7:0] eoi_vector;

  logic b_req_ready, b_rsp_valid, b_chg, b_eoi;
  logic [31:0] b_rdata;
  logic [NPINS*64-1:0] b_table;
  logic [IDX_W-1:0] b_idx;
  logic [7:0] b_vec;

  int checks = 0, errors = 0;
  bit done = 0;
  logic s_chg, s_eoi, s_b_eoi;
  logic [IDX_W-1:0] s_idx;
  logic [7:0] s_vec;
  logic [31:0] s_b_rdata;

  always #2 clk = ~clk;

  irq_route_regs #(.NPINS(NPINS), .VERSION(8'h20)) u_irq_route_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_full(req_full), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .pin_busy(pin_busy), .rirr_set(rirr_set), .rirr_clr(rirr_clr), .table_flat(table_flat),
    .ent_chg_valid(ent_chg_valid), .ent_chg_idx(ent_chg_idx),
    .eoi_valid(eoi_valid), .eoi_vector(eoi_vector));

  irq_route_regs #(.NPINS(NPINS), .VERSION(8'h11)) u_irq_route_regs_v11 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(b_req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_full(req_full), .req_wdata(req_wdata),
    .rsp_valid(b_rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(b_rdata),
    .pin_busy(pin_busy), .rirr_set(rirr_set), .rirr_clr(rirr_clr), .table_flat(b_table),
    .ent_chg_valid(b_chg), .ent_chg_idx(b_idx), .eoi_valid(b_eoi), .eoi_vector(b_vec));

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d, logic full = 1'b1,
                        logic [NPINS-1:0] setm = '0);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_full = full;
    rirr_set = setm;
    @(posedge clk); #1;
    s_chg = ent_chg_valid; s_idx = ent_chg_idx; s_eoi = eoi_valid; s_vec = eoi_vector;
    s_b_eoi = b_eoi;
    req_valid = 1'b0; rirr_set = '0; req_full = 1'b1;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d, input logic full = 1'b1);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_full = full;
    @(posedge clk); #1;
    check("R11 read response valid", 64'(rsp_valid), 64'd1);
    d = rsp_rdata; s_b_rdata = b_rdata;
    req_valid = 1'b0; req_full = 1'b1;
  endtask

  task automatic win_rd_at(logic [7:0] s, output logic [31:0] d);
    bus_wr(8'h00, 32'(s));
    bus_rd(8'h10, d);
  endtask

  task automatic strobe(logic [NPINS-1:0] setm, logic [NPINS-1:0] clrm);
    @(negedge clk); rirr_set = setm; rirr_clr = clrm;
    @(negedge clk); rirr_set = '0; rirr_clr = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bus_rd(8'h00, d);        check("R1 select after reset", 64'(d), 64'h0);
    bus_rd(8'h10, d);        check("R1 ID after reset", 64'(d), 64'h0);
    win_rd_at(8'h10, d);     check("R1 entry0 low after reset", 64'(d), 64'h0001_0000);
    win_rd_at(8'h3F, d);     check("R1 entry23 high after reset", 64'(d), 64'h0);
    check("R1 table flat entry 9", table_flat[9*64 +: 64], 64'h0000_0000_0001_0000);
  endtask

  task automatic t_select();
    logic [31:0] d;
    bus_wr(8'h00, 32'hABCD_012A);
    bus_rd(8'h00, d);        check("R2 select readback", 64'(d), 64'h2A);
    bus_rd(8'h20, d);        check("R2 unmapped offset reads zero", 64'(d), 64'h0);
  endtask

  task automatic t_id_ver();
    logic [31:0] d;
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, d);        check("R3 ID field only", 64'(d), 64'h0F00_0000);
    bus_wr(8'h00, 32'h2);
    bus_rd(8'h10, d);        check("R3 arbitration mirrors ID", 64'(d), 64'h0F00_0000);
    bus_wr(8'h10, 32'h0);
    bus_rd(8'h10, d);        check("R4 arbitration write ignored", 64'(d), 64'h0F00_0000);
    bus_wr(8'h00, 32'h1);
    bus_rd(8'h10, d);        check("R4 version word", 64'(d), 64'h0017_0020);
    check("R4 version word variant 0x11", 64'(s_b_rdata), 64'h0017_0011);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    bus_rd(8'h10, d);        check("R4 version write ignored", 64'(d), 64'h0017_0020);
  endtask

  task automatic t_table();
    logic [31:0] d;
    bus_wr(8'h00, 32'h1A);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    check("R8 change pulse", 64'(s_chg), 64'd1);
    check("R8 change index", 64'(s_idx), 64'd5);
    bus_rd(8'h10, d);        check("R6 lower half rw bits", 64'(d), 64'h0001_AFFF);
    bus_wr(8'h00, 32'h1B);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    check("R8 change index upper", 64'(s_idx), 64'd5);
    bus_rd(8'h10, d);        check("R5 upper half odd select", 64'(d), 64'hFF00_0000);
    pin_busy = 24'(1) << 5;
    win_rd_at(8'h1A, d);     check("R6 busy bit live", 64'(d), 64'h0001_BFFF);
    pin_busy = '0;
    bus_wr(8'h00, 32'h3E);
    bus_wr(8'h10, 32'h5);    check("R5 last entry in range", 64'(s_idx), 64'd23);
    bus_rd(8'h10, d);        check("R5 last entry value", 64'(d), 64'h5);
    bus_wr(8'h00, 32'h40);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    check("R5 out of range no change pulse", 64'(s_chg), 64'd0);
    bus_rd(8'h10, d);        check("R5 out of range reads zero", 64'(d), 64'h0);
    bus_wr(8'h00, 32'h0F);
    bus_wr(8'h10, 32'hFFFF_FFFF);
    check("R5 below base no change pulse", 64'(s_chg), 64'd0);
    bus_rd(8'h10, d);        check("R5 below base reads zero", 64'(d), 64'h0);
    check("R5 other entries untouched", table_flat[6*64 +: 64], 64'h0000_0000_0001_0000);
  endtask

  task automatic t_remote_irr();
    logic [31:0] d;
    bus_wr(8'h00, 32'h16);
    bus_wr(8'h10, 32'h0000_8031);
    strobe(24'(1) << 3, '0);
    bus_rd(8'h10, d);        check("R12 set strobe", 64'(d), 64'hC031);
    bus_wr(8'h10, 32'h0000_8031);
    bus_rd(8'h10, d);        check("R6 level write keeps remote IRR", 64'(d), 64'hC031);
    bus_wr(8'h00, 32'h17);
    bus_wr(8'h10, 32'h0100_0000);
    check("R6 flat entry 3", table_flat[3*64 +: 64], 64'h0100_0000_0000_C031);
    bus_wr(8'h00, 32'h16);
    bus_wr(8'h10, 32'h0000_4031);
    bus_rd(8'h10, d);        check("R7 edge write clears remote IRR", 64'(d), 64'h0031);
    bus_wr(8'h10, 32'h0000_8031, 1'b1, 24'(1) << 3);
    bus_rd(8'h10, d);        check("R12 set with level write", 64'(d), 64'hC031);
    bus_wr(8'h10, 32'h0000_0031, 1'b1, 24'(1) << 3);
    bus_rd(8'h10, d);        check("R12 set with edge write", 64'(d), 64'h0031);
    bus_wr(8'h10, 32'h0000_8031);
    strobe(24'(1) << 3, '0);
    strobe('0, 24'(1) << 3);
    bus_rd(8'h10, d);        check("R12 clear strobe", 64'(d), 64'h8031);
    strobe(24'(1) << 3, 24'(1) << 3);
    bus_rd(8'h10, d);        check("R12 set wins over clear", 64'(d), 64'hC031);
  endtask

  task automatic t_narrow();
    logic [31:0] d;
    bus_wr(8'h10, 32'h0, 1'b0);
    check("R9 narrow write no change pulse", 64'(s_chg), 64'd0);
    bus_rd(8'h10, d);        check("R9 narrow write ignored", 64'(d), 64'hC031);
    bus_rd(8'h10, d, 1'b0);  check("R9 narrow read zero", 64'(d), 64'h0);
  endtask

  task automatic t_eoi();
    bus_wr(8'h40, 32'h1234_5655);
    check("R10 eoi pulse", 64'(s_eoi), 64'd1);
    check("R10 eoi vector", 64'(s_vec), 64'h55);
    check("R10 version 0x11 no eoi", 64'(s_b_eoi), 64'd0);
    bus_wr(8'h40, 32'h77, 1'b0);
    check("R10 narrow eoi ignored", 64'(s_eoi), 64'd0);
    bus_wr(8'h44, 32'h77);
    check("R10 other offset no eoi", 64'(s_eoi), 64'd0);
  endtask

  task automatic t_backpressure();
    logic [31:0] d, first;
    bus_wr(8'h00, 32'h02);
    rsp_ready = 1'b0;
    bus_rd(8'h00, first);
    check("R11 held read data", 64'(first), 64'h02);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h00; req_wdata = 32'h77;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R11 response held", 64'(rsp_valid), 64'd1);
      check("R11 data stable", 64'(rsp_rdata), 64'(first));
      check("R11 request stalled", 64'(req_ready), 64'd0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R11 response taken", 64'(rsp_valid), 64'd0);
    bus_rd(8'h00, d);        check("R11 stalled write not taken", 64'(d), 64'h02);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_select();
    t_id_ver();
    t_table();
    t_remote_irr();
    t_narrow();
    t_eoi();
    t_backpressure();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule